// File: doc/BRIEF.md
# Multi-Channel Interprocessor Message Box

This block lets two processors, called the local side and the remote side, pass 32-bit words to each other. It holds eight independent channels, and each channel is a small first-in first-out queue of four messages. Both processors reach the block through one shared 32-bit register port; an arbiter upstream of the block decides whose access goes through. Writing a channel's data register adds a message to the queue, and reading it removes the oldest message.

Each channel carries traffic in one direction, and software chooses that direction with two bits per channel in the control words. The "local receives" bit routes the channel's data-waiting interrupt to the local bank and its space-available interrupt to the remote bank. The "local transmits" bit routes them the other way. Each side has its own enable and status pair, and each side has its own interrupt line. A data-waiting status bit cannot be acknowledged while its queue still holds messages, so a receiver that returns from its handler too early is interrupted again.

Top module: `ipc_mailbox`

## Requirements
- R1: After reset, the control words, all four interrupt registers and every channel count read 0, and both interrupt outputs are low.
- R2: For channel n, a write to 0x180+4n adds a message and a read from it returns the oldest message and removes it. Messages come out in the order they went in.
- R3: The count register at 0x140+4n reads the number of queued messages, from 0 to 4, in bits [2:0]. Bit 0 of 0x100+4n reads 1 exactly when the queue holds 4 messages.
- R4: A write to a full queue is discarded. The count stays at 4 and the four older messages come out unchanged.
- R5: A read from an empty queue returns 0 and leaves the count at 0.
- R6: Control word 0x00 covers channels 0 to 3 and 0x04 covers channels 4 to 7. For channel n, bit 8*(n%4) is "local receives" and bit 8*(n%4)+4 is "local transmits". All other bits of these words read 0.
- R7: Local status (0x70): bit 2n is set while channel n holds data and its local-receives bit is 1. Bit 2n+1 is set while channel n is not full and its local-transmits bit is 1.
- R8: Remote status (0x50): bit 2n is set while channel n holds data and its local-transmits bit is 1. Bit 2n+1 is set while channel n is not full and its local-receives bit is 1.
- R9: Writing 1 to a status bit clears it. A data-waiting bit (2n) stays set if channel n still holds messages at that write. A bit whose set condition still holds is set again on the next cycle. Status bits stay set after their condition ends, until they are cleared.
- R10: irq_local is high when any bit is set in both local status and local enable (0x60). irq_remote is the same for remote status and remote enable (0x40). Enable registers read back what was written.
- R11: Activity on one channel leaves the count and the contents of every other channel unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for one cycle |
| reg_rd | input | 1 | Read strobe; removes a message when the address is a data register |
| reg_addr | input | 9 | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from reg_addr |
| irq_local | output | 1 | Interrupt to the local processor |
| irq_remote | output | 1 | Interrupt to the remote processor |

## Verification
The assertions assume that reg_wr and reg_rd are never high in the same cycle. The shared port serves one access at a time, so a cycle that both adds and removes a message does not occur. The bench drives each access from a task that raises exactly one strobe for one cycle. It holds the address stable during that cycle and leaves idle cycles before it reads status. The interrupt checks also assume that status reflects the queue state one cycle late, so the bench reads no status in the cycle right after a queue changes.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
   localparam int REG_W      = 32;
   localparam int CTRL_BASE  = 'h000;
   localparam int REM_EN_OFS = 'h040;
   localparam int REM_ST_OFS = 'h050;
   localparam int LOC_EN_OFS = 'h060;
   localparam int LOC_ST_OFS = 'h070;
   localparam int FULL_BASE  = 'h100;
   localparam int CNT_BASE   = 'h140;
   localparam int DATA_BASE  = 'h180;
   localparam int CH_PER_CTL = 4;
   localparam int CTL_STRIDE = 8;
   localparam int TX_SHIFT   = 4;
endpackage

// File: rtl/mbox_fifo.sv
module mbox_fifo #(
   parameter int W     = 32,
   parameter int DEPTH = 4
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         push,
   input  logic                         pop,
   input  logic [W-1:0]                 din,
   output logic [W-1:0]                 dout,
   output logic [$clog2(DEPTH+1)-1:0]   count,
   output logic                         full,
   output logic                         empty
);
   localparam int PW = $clog2(DEPTH);
   localparam int CW = $clog2(DEPTH+1);

   if (DEPTH < 2 || (DEPTH & (DEPTH-1)) != 0) begin : g_bad_depth
      $error("mbox_fifo: DEPTH must be a power of two, at least 2");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] wp, rp;
   logic          do_push, do_pop;

   assign full    = (count == CW'(DEPTH));
   assign empty   = (count == '0);
   assign do_push = push & ~full;
   assign do_pop  = pop & ~empty;
   assign dout    = empty ? '0 : mem[rp];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp    <= '0;
         rp    <= '0;
         count <= '0;
      end else begin
         if (do_push) wp <= wp + 1'b1;
         if (do_pop)  rp <= rp + 1'b1;
         count <= count + {{(CW-1){1'b0}}, do_push} - {{(CW-1){1'b0}}, do_pop};
      end
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wp] <= din;
   end

   // R3
   count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CW'(DEPTH));
   // R4
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (full && push && !pop) |=> (count == CW'(DEPTH)));
   // R5
   no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (empty && pop && !push) |=> (count == '0));
endmodule

// File: rtl/mbox_irq_bank.sv
module mbox_irq_bank #(
   parameter int NCH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NCH-1:0]   rx_cond,
   input  logic [NCH-1:0]   tx_cond,
   input  logic [NCH-1:0]   fifo_empty,
   input  logic             en_we,
   input  logic             st_we,
   input  logic [2*NCH-1:0] wbits,
   output logic [2*NCH-1:0] en,
   output logic [2*NCH-1:0] st,
   output logic             irq
);
   assign irq = |(st & en);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     en <= '0;
      else if (en_we) en <= wbits;
   end

   for (genvar n = 0; n < NCH; n++) begin : g_ch
      logic rx_clr, tx_clr;
      assign rx_clr = st_we & wbits[2*n] & fifo_empty[n];
      assign tx_clr = st_we & wbits[2*n+1];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            st[2*n]   <= 1'b0;
            st[2*n+1] <= 1'b0;
         end else begin
            st[2*n]   <= rx_cond[n] | (st[2*n]   & ~rx_clr);
            st[2*n+1] <= tx_cond[n] | (st[2*n+1] & ~tx_clr);
         end
      end

      // R9
      rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (st[2*n] && !fifo_empty[n]) |=> st[2*n]);
      // R10
      tx_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (tx_cond[n] && en[2*n+1] && !en_we) |=> irq);
   end
endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox #(
   parameter int NCH   = 8,
   parameter int DEPTH = 4,
   parameter int MSG_W = 32,
   parameter int AW    = 9
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   reg_wr,
   input  logic                   reg_rd,
   input  logic [AW-1:0]          reg_addr,
   input  logic [mbox_pkg::REG_W-1:0] reg_wdata,
   output logic [mbox_pkg::REG_W-1:0] reg_rdata,
   output logic                   irq_local,
   output logic                   irq_remote
);
   import mbox_pkg::*;

   localparam int CW     = $clog2(DEPTH+1);
   localparam int NCTL   = NCH / CH_PER_CTL;
   localparam int IRQ_W  = 2 * NCH;

   if (NCH % CH_PER_CTL != 0 || NCH > 16) begin : g_bad_nch
      $error("ipc_mailbox: NCH must be a multiple of 4 and at most 16");
   end
   if (MSG_W > REG_W || CW > REG_W) begin : g_bad_w
      $error("ipc_mailbox: MSG_W must fit in a register");
   end
   if ((1 << AW) <= DATA_BASE + 4*NCH) begin : g_bad_aw
      $error("ipc_mailbox: AW too small for the register map");
   end

   logic [NCH-1:0]   ctl_rx, ctl_tx;
   logic [NCH-1:0]   push, pop, full, empty;
   logic [MSG_W-1:0] fifo_out [NCH];
   logic [CW-1:0]    fifo_cnt [NCH];
   logic [IRQ_W-1:0] loc_en, loc_st, rem_en, rem_st;

   function automatic logic hit(input logic [AW-1:0] a, input int ofs);
      return a == AW'(ofs);
   endfunction

   for (genvar n = 0; n < NCH; n++) begin : g_chan
      assign push[n] = reg_wr & hit(reg_addr, DATA_BASE + 4*n);
      assign pop[n]  = reg_rd & hit(reg_addr, DATA_BASE + 4*n);

      mbox_fifo #(.W(MSG_W), .DEPTH(DEPTH)) u_fifo (
         .clk   (clk),
         .rst_n (rst_n),
         .push  (push[n]),
         .pop   (pop[n]),
         .din   (reg_wdata[MSG_W-1:0]),
         .dout  (fifo_out[n]),
         .count (fifo_cnt[n]),
         .full  (full[n]),
         .empty (empty[n])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_rx <= '0;
         ctl_tx <= '0;
      end else if (reg_wr) begin
         for (int w = 0; w < NCTL; w++) begin
            if (hit(reg_addr, CTRL_BASE + 4*w)) begin
               for (int k = 0; k < CH_PER_CTL; k++) begin
                  ctl_rx[w*CH_PER_CTL+k] <= reg_wdata[CTL_STRIDE*k];
                  ctl_tx[w*CH_PER_CTL+k] <= reg_wdata[CTL_STRIDE*k+TX_SHIFT];
               end
            end
         end
      end
   end

   mbox_irq_bank #(.NCH(NCH)) u_loc_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .rx_cond    (~empty & ctl_rx),
      .tx_cond    (~full & ctl_tx),
      .fifo_empty (empty),
      .en_we      (reg_wr & hit(reg_addr, LOC_EN_OFS)),
      .st_we      (reg_wr & hit(reg_addr, LOC_ST_OFS)),
      .wbits      (reg_wdata[IRQ_W-1:0]),
      .en         (loc_en),
      .st         (loc_st),
      .irq        (irq_local)
   );

   mbox_irq_bank #(.NCH(NCH)) u_rem_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .rx_cond    (~empty & ctl_tx),
      .tx_cond    (~full & ctl_rx),
      .fifo_empty (empty),
      .en_we      (reg_wr & hit(reg_addr, REM_EN_OFS)),
      .st_we      (reg_wr & hit(reg_addr, REM_ST_OFS)),
      .wbits      (reg_wdata[IRQ_W-1:0]),
      .en         (rem_en),
      .st         (rem_st),
      .irq        (irq_remote)
   );

   always_comb begin
      reg_rdata = '0;
      for (int w = 0; w < NCTL; w++) begin
         if (hit(reg_addr, CTRL_BASE + 4*w)) begin
            for (int k = 0; k < CH_PER_CTL; k++) begin
               reg_rdata[CTL_STRIDE*k]          = ctl_rx[w*CH_PER_CTL+k];
               reg_rdata[CTL_STRIDE*k+TX_SHIFT] = ctl_tx[w*CH_PER_CTL+k];
            end
         end
      end
      if (hit(reg_addr, REM_EN_OFS)) reg_rdata[IRQ_W-1:0] = rem_en;
      if (hit(reg_addr, REM_ST_OFS)) reg_rdata[IRQ_W-1:0] = rem_st;
      if (hit(reg_addr, LOC_EN_OFS)) reg_rdata[IRQ_W-1:0] = loc_en;
      if (hit(reg_addr, LOC_ST_OFS)) reg_rdata[IRQ_W-1:0] = loc_st;
      for (int n = 0; n < NCH; n++) begin
         if (hit(reg_addr, FULL_BASE + 4*n)) reg_rdata[0]          = full[n];
         if (hit(reg_addr, CNT_BASE + 4*n))  reg_rdata[CW-1:0]     = fifo_cnt[n];
         if (hit(reg_addr, DATA_BASE + 4*n)) reg_rdata[MSG_W-1:0]  = fifo_out[n];
      end
   end

   // input rule for the shared port: one access per cycle
   one_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_wr && reg_rd));
   // R1
   reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!irq_local && !irq_remote));
endmodule

// File: tb/tb_ipc_mailbox.sv
`timescale 1ns/1ps
module tb_ipc_mailbox;
   localparam int DATA = 'h180, CNT = 'h140, FUL = 'h100;

   logic        clk = 1'b0, rst_n = 1'b0;
   logic        reg_wr = 1'b0, reg_rd = 1'b0;
   logic [8:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0, reg_rdata;
   logic        irq_local, irq_remote;

   int total = 0, bad = 0;
   logic [31:0] mq [8][$];

   always #2 clk = ~clk;

   ipc_mailbox dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .irq_local(irq_local), .irq_remote(irq_remote)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic bus_wr(input int a, input logic [31:0] d);
      @(negedge clk);
      reg_addr = 9'(a); reg_wdata = d; reg_wr = 1'b1;
      @(posedge clk); #1 reg_wr = 1'b0;
   endtask

   task automatic bus_rd(input int a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = 9'(a); reg_rd = 1'b1;
      #1 d = reg_rdata;
      @(posedge clk); #1 reg_rd = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic rd_chk(input string tag, input int a, input logic [31:0] exp);
      logic [31:0] d;
      bus_rd(a, d);
      chk(tag, d, exp);
   endtask

   // scoreboard driver: send a message and record what must come back
   task automatic send(input int ch, input logic [31:0] d);
      bus_wr(DATA + 4*ch, d);
      if (mq[ch].size() < 4) mq[ch].push_back(d);
   endtask

   // scoreboard monitor: take a message and compare with the oldest expected
   task automatic recv(input int ch, input string tag);
      logic [31:0] d, e;
      bus_rd(DATA + 4*ch, d);
      e = (mq[ch].size() > 0) ? mq[ch].pop_front() : 32'h0;
      chk(tag, d, e);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog R1 act=timeout exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      idle(3); rst_n = 1'b1; idle(2);
      // R1 reset state
      rd_chk("R1 ctrl0", 'h00, 0);
      rd_chk("R1 ctrl1", 'h04, 0);
      rd_chk("R1 rem_en", 'h40, 0);
      rd_chk("R1 rem_st", 'h50, 0);
      rd_chk("R1 loc_en", 'h60, 0);
      rd_chk("R1 loc_st", 'h70, 0);
      for (int c = 0; c < 8; c++) rd_chk("R1 count", CNT + 4*c, 0);
      chk("R1 irq_local", {31'b0, irq_local}, 0);
      chk("R1 irq_remote", {31'b0, irq_remote}, 0);

      // R6 control layout
      bus_wr('h00, 32'hFFFF_FFFF);
      rd_chk("R6 ctrl0 mask", 'h00, 32'h1111_1111);
      bus_wr('h00, 32'h0000_0001);   // ch0 local receives
      bus_wr('h04, 32'h0000_1000);   // ch5 local transmits
      rd_chk("R6 ctrl0", 'h00, 32'h1);
      rd_chk("R6 ctrl1", 'h04, 32'h1000);
      idle(2);
      bus_wr('h70, 32'hFFFF_FFFF);
      bus_wr('h50, 32'hFFFF_FFFF);
      idle(2);
      // R7 / R8 with empty queues
      rd_chk("R7 loc_st tx ch5", 'h70, 32'h800);
      rd_chk("R8 rem_st tx ch0", 'h50, 32'h2);

      // R2 / R3 order and count on ch0
      send(0, 32'hA1A1_0001);
      send(0, 32'hB2B2_0002);
      send(0, 32'hC3C3_0003);
      idle(2);
      rd_chk("R3 count ch0", CNT, 3);
      rd_chk("R3 full ch0", FUL, 0);
      rd_chk("R7 loc_st rx ch0", 'h70, 32'h801);
      rd_chk("R8 rem_st ch0", 'h50, 32'h2);

      // R9 clear blocked while data remains
      bus_wr('h70, 32'h1);
      idle(2);
      rd_chk("R9 rx held", 'h70, 32'h801);

      recv(0, "R2 pop1");
      recv(0, "R2 pop2");
      recv(0, "R2 pop3");
      rd_chk("R3 count ch0 empty", CNT, 0);
      recv(0, "R5 pop empty");
      rd_chk("R5 count stays", CNT, 0);
      idle(1);
      rd_chk("R9 rx sticky", 'h70, 32'h801);
      bus_wr('h70, 32'h1);
      idle(2);
      rd_chk("R9 rx cleared", 'h70, 32'h800);

      // R11 independence
      send(2, 32'h2222_0001);
      send(2, 32'h2222_0002);
      idle(1);
      rd_chk("R11 count ch2", CNT + 8, 2);
      rd_chk("R11 count ch0", CNT, 0);
      rd_chk("R11 count ch5", CNT + 20, 0);

      // R10 enables and lines
      chk("R10 irq_local off", {31'b0, irq_local}, 0);
      bus_wr('h60, 32'h800);
      idle(1);
      chk("R10 irq_local on", {31'b0, irq_local}, 1);
      rd_chk("R10 loc_en", 'h60, 32'h800);
      bus_wr('h40, 32'h400);
      idle(2);
      chk("R10 irq_remote off", {31'b0, irq_remote}, 0);

      // R4 overflow on ch5
      for (int i = 0; i < 5; i++) send(5, 32'h5500_0000 + 32'(i));
      idle(2);
      rd_chk("R4 count ch5", CNT + 20, 4);
      rd_chk("R3 full ch5", FUL + 20, 1);
      rd_chk("R8 rem_st rx ch5", 'h50, 32'h402);
      chk("R10 irq_remote on", {31'b0, irq_remote}, 1);
      bus_wr('h70, 32'h800);
      idle(2);
      rd_chk("R9 tx cleared when full", 'h70, 32'h0);
      chk("R10 irq_local off", {31'b0, irq_local}, 0);
      for (int i = 0; i < 4; i++) recv(5, "R4 pop order");
      recv(5, "R5 pop empty ch5");
      rd_chk("R4 count ch5 zero", CNT + 20, 0);
      idle(2);
      chk("R10 irq_local again", {31'b0, irq_local}, 1);

      recv(2, "R11 ch2 pop1");
      recv(2, "R11 ch2 pop2");
      rd_chk("R11 count ch2 zero", CNT + 8, 0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule